// File: doc/BRIEF.md
# Programmable-Trigger External Interrupt Controller

The block gathers up to 32 external interrupt pins. Each pin has its own trigger setting: active-low level, active-high level, rising edge, falling edge, or either edge. Every pin first passes through a two-flop synchronizer. A per-line detector then compares the synchronised level with the sense code stored for that line. When the condition holds, the detector sets a sticky detect bit.

Software enables lines through a write-one-to-set register and disables them through a write-one-to-clear register. It acknowledges a detection by writing one to the detect bit. Each line drives its own interrupt output, which is the detect bit gated by the enable bit. A combined request register shows the same gated value for all lines at once. A monitor register returns the raw synchronised pin levels.

All access goes through a 32-bit register port. A read strobe returns data on the following cycle. A write takes effect at the clock edge that samples it.

Top module: `eic_top`

## Requirements
- R1: Each pin is synchronised by two flops. A pin change driven before clock edge k appears at bit n of the monitor register (offset 0x104) when a read is issued in the cycle after edge k+1.
- R2: Line n's sense field is bits [5:0] of the register at offset 0x180 + 4*n. It reads back as written, and bits [31:6] read as zero.
- R3: Sense code 0x01 sets the detect bit while the synchronised pin is low. Sense code 0x02 sets it while the synchronised pin is high.
- R4: Sense code 0x08 detects a rising edge and 0x04 detects a falling edge. Sense code 0x0C detects both. An edge is a difference between the synchronised value and its value one cycle earlier. A steady level after the edge sets nothing further.
- R5: Any other sense code, including the reset value 0x00, never sets the detect bit.
- R6: The detect register is at offset 0x100. Writing 1 to bit n clears line n's detect bit, and writing 0 leaves it unchanged. A detect bit never falls without such a write. A detection in the same cycle as a clear wins.
- R7: In level mode, a clear write does not remove the detect bit while the active level persists.
- R8: Writing 1 to bit n of the enable-set register (offset 0x08) enables line n. Writing 0 has no effect.
- R9: Reading offset 0x04 returns the enable mask. Writing 1 to bit n there disables line n, and writing 0 has no effect.
- R10: Reading offset 0x00 returns the detect bits ANDed with the enable mask.
- R11: irq_o[n] is high exactly when line n is both detected and enabled.
- R12: Reset clears all enables, all detect bits, all sense fields, the read data and irq_o.
- R13: Read data updates only on the edge after a read strobe and holds otherwise. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | NUM_LINES | External interrupt pins (asynchronous) |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe; data returned next cycle |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_LINES | Per-line interrupt outputs |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as a fresh detection. That detection may come from a new edge or from a level that is still active, and the clear must lose. Random stimulus toggles pins sparsely while writing random masks to the detect register every few cycles. A cycle-exact model in the bench tracks the synchroniser delay, so this collision occurs many times and is checked on every cycle. Directed sequences also hold a level active across a clear, and they show that an unrecognised sense code absorbs edges without effect.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int DATA_W  = 32;
  localparam int SENSE_W = 6;

  localparam int OFF_REQ  = 'h000;
  localparam int OFF_ENST = 'h004;
  localparam int OFF_ENSET = 'h008;
  localparam int OFF_DET  = 'h100;
  localparam int OFF_MON  = 'h104;
  localparam int OFF_CFG  = 'h180;

  typedef logic [SENSE_W-1:0] sense_t;

  localparam sense_t SENSE_LOW  = 6'h01;
  localparam sense_t SENSE_HIGH = 6'h02;
  localparam sense_t SENSE_FALL = 6'h04;
  localparam sense_t SENSE_RISE = 6'h08;
  localparam sense_t SENSE_BOTH = 6'h0C;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/eic_line_detect.sv
module eic_line_detect
  import eic_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   lvl_i,
  input  sense_t sense_i,
  input  logic   clr_i,
  output logic   det_o
);
  logic prev_q, det_q, hit;
  logic rise, fall;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    case (sense_i)
      SENSE_LOW:  hit = ~lvl_i;
      SENSE_HIGH: hit = lvl_i;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  // a new event outranks an acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (hit)        det_q <= 1'b1;
      else if (clr_i) det_q <= 1'b0;
    end
  end

  assign det_o = det_q;
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic                 we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 re_i,
  input  logic [N-1:0]         det_i,
  input  logic [N-1:0]         mon_i,
  output logic [N-1:0]         en_o,
  output logic [N-1:0]         clr_o,
  output logic [N-1:0][SENSE_W-1:0] cfg_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam logic [AW-1:0] A_REQ   = AW'(OFF_REQ);
  localparam logic [AW-1:0] A_ENST  = AW'(OFF_ENST);
  localparam logic [AW-1:0] A_ENSET = AW'(OFF_ENSET);
  localparam logic [AW-1:0] A_DET   = AW'(OFF_DET);
  localparam logic [AW-1:0] A_MON   = AW'(OFF_MON);

  logic [N-1:0]              en_q;
  logic [N-1:0][SENSE_W-1:0] cfg_q;
  logic [DATA_W-1:0]         rd_mux, rdata_q;
  logic [N-1:0]              wmask;

  function automatic logic [AW-1:0] cfg_addr(input int idx);
    return AW'(OFF_CFG + 4 * idx);
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [N-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[N-1:0] = v;
    return r;
  endfunction

  assign wmask = wdata_i[N-1:0];
  assign clr_o = (we_i && addr_i == A_DET) ? wmask : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_ENSET)     en_q <= en_q | wmask;
      else if (addr_i == A_ENST) en_q <= en_q & ~wmask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N; i++) begin
        if (addr_i == cfg_addr(i)) cfg_q[i] <= wdata_i[SENSE_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_REQ)        rd_mux = widen(det_i & en_q);
    else if (addr_i == A_ENST)  rd_mux = widen(en_q);
    else if (addr_i == A_DET)   rd_mux = widen(det_i);
    else if (addr_i == A_MON)   rd_mux = widen(mon_i);
    for (int i = 0; i < N; i++) begin
      if (addr_i == cfg_addr(i)) rd_mux = DATA_W'(cfg_q[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign en_o    = en_q;
  assign cfg_o   = cfg_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_pin_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 re_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_LINES-1:0]              lvl_sync, det_vec, en_mask, clr_vec;
  logic [NUM_LINES-1:0][SENSE_W-1:0] cfg;

  eic_sync #(.W(NUM_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_pin_i),
    .q_o    (lvl_sync)
  );

  eic_regs #(.N(NUM_LINES), .AW(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .re_i    (re_i),
    .det_i   (det_vec),
    .mon_i   (lvl_sync),
    .en_o    (en_mask),
    .clr_o   (clr_vec),
    .cfg_o   (cfg),
    .rdata_o (rdata_o)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    eic_line_detect u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lvl_i   (lvl_sync[g]),
      .sense_i (cfg[g]),
      .clr_i   (clr_vec[g]),
      .det_o   (det_vec[g])
    );
  end

  assign irq_o = det_vec & en_mask;
endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import eic_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N-1:0]      irq_o,
  input logic [N-1:0]      en_i,
  input logic [N-1:0]      det_i
);
  localparam logic [AW-1:0] A_REQ   = AW'(OFF_REQ);
  localparam logic [AW-1:0] A_ENST  = AW'(OFF_ENST);
  localparam logic [AW-1:0] A_ENSET = AW'(OFF_ENSET);
  localparam logic [AW-1:0] A_DET   = AW'(OFF_DET);

  assert_det_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_DET) |=> ((det_i & $past(det_i)) == $past(det_i)));

  assert_en_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ENSET) |=> ((en_i & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));

  assert_en_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ENST) |=> ((en_i & $past(wdata_i[N-1:0])) == '0));

  assert_req_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == A_REQ) |=> (rdata_o[N-1:0] == $past(irq_o)));

  assert_rdata_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R12: assert (irq_o == '0 && rdata_o == '0 && en_i == '0);
    end
  end
endmodule

bind eic_top eic_checker #(.N(NUM_LINES), .AW(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .en_i    (en_mask),
  .det_i   (det_vec)
);

// File: tb/tb_eic_top.sv
`timescale 1ns/1ps
module tb_eic_top;
  localparam int N = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eic_top #(.NUM_LINES(N), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pins), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .re_i(re), .rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- reference model ----------------
  logic [N-1:0] m_s1, m_s2, m_prev, m_det, m_en;
  logic [5:0]   m_cfg [N];
  logic [31:0]  m_rd;
  logic         m_rd_v;
  logic [AW-1:0] m_rd_addr;

  function automatic bit f_hit(input logic [5:0] s, input logic l, input logic p);
    case (s)
      6'h01: return !l;
      6'h02: return l;
      6'h04: return !l && p;
      6'h08: return l && !p;
      6'h0C: return l != p;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] f_read(input logic [AW-1:0] a);
    if (a == 12'h000) return m_det & m_en;
    if (a == 12'h004) return m_en;
    if (a == 12'h100) return m_det;
    if (a == 12'h104) return m_s2;
    for (int i = 0; i < N; i++)
      if (a == AW'(12'h180 + 4 * i)) return {26'b0, m_cfg[i]};
    return 32'h0;
  endfunction

  function automatic string f_tag(input logic [AW-1:0] a);
    if (a == 12'h000) return "R10";
    if (a == 12'h004) return "R9";
    if (a == 12'h100) return "R6";
    if (a == 12'h104) return "R1";
    if (a >= 12'h180 && a < 12'h200) return "R2";
    return "R13";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_det <= '0; m_en <= '0;
      for (int i = 0; i < N; i++) m_cfg[i] <= '0;
      m_rd <= '0; m_rd_v <= 0; m_rd_addr <= '0;
    end else begin
      m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
      for (int i = 0; i < N; i++) begin
        if (f_hit(m_cfg[i], m_s2[i], m_prev[i])) m_det[i] <= 1'b1;
        else if (we && addr == 12'h100 && wdata[i]) m_det[i] <= 1'b0;
        if (we && addr == AW'(12'h180 + 4 * i)) m_cfg[i] <= wdata[5:0];
      end
      if (we && addr == 12'h008) m_en <= m_en | wdata;
      if (we && addr == 12'h004) m_en <= m_en & ~wdata;
      if (re) m_rd <= f_read(addr);
      m_rd_v <= re;
      m_rd_addr <= addr;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11", 32'(irq), 32'(m_det & m_en));
      if (m_rd_v) check(f_tag(m_rd_addr), rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1; re = 0;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1; we = 0;
    @(negedge clk);
    d = rdata;
    re = 0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    idle(3);
    check("R12", 32'(irq), 32'h0);
    check("R12", rdata, 32'h0);
    rst_n = 1;
    idle(2);
    rd(12'h004, d); check("R12", d, 32'h0);
    rd(12'h100, d); check("R12", d, 32'h0);
    rd(12'h184, d); check("R12", d, 32'h0);

    // high level on line 0, enabled
    wr(12'h180, 32'hFFFF_FF02);
    rd(12'h180, d); check("R2", d, 32'h02);
    wr(12'h008, 32'h1);
    pins[0] = 1; idle(4);
    rd(12'h100, d); check("R3", d & 32'h1, 32'h1);
    check("R11", 32'(irq) & 32'h1, 32'h1);
    pins[0] = 0; idle(3);
    wr(12'h100, 32'h0); rd(12'h100, d); check("R6", d & 32'h1, 32'h1);
    wr(12'h100, 32'h1); rd(12'h100, d); check("R6", d & 32'h1, 32'h0);

    // low level on line 1 persists through clear
    wr(12'h184, 32'h01); idle(3);
    wr(12'h100, 32'h2); rd(12'h100, d); check("R7", d & 32'h2, 32'h2);
    pins[1] = 1; idle(4);
    wr(12'h100, 32'h2); rd(12'h100, d); check("R3", d & 32'h2, 32'h0);

    // rising edge line 2
    wr(12'h188, 32'h08);
    pins[2] = 1; idle(4);
    rd(12'h100, d); check("R4", d & 32'h4, 32'h4);
    wr(12'h100, 32'h4); idle(3);
    rd(12'h100, d); check("R4", d & 32'h4, 32'h0);
    // falling edge line 3
    pins[3] = 1; wr(12'h18C, 32'h04); idle(3);
    pins[3] = 0; idle(4);
    rd(12'h100, d); check("R4", d & 32'h8, 32'h8);
    // both edges line 4
    wr(12'h190, 32'h0C);
    pins[4] = 1; idle(4);
    wr(12'h100, 32'h10); rd(12'h100, d); check("R4", d & 32'h10, 32'h0);
    pins[4] = 0; idle(4);
    rd(12'h100, d); check("R4", d & 32'h10, 32'h10);

    // unknown code line 5
    wr(12'h194, 32'h10);
    pins[5] = 1; idle(4); pins[5] = 0; idle(4);
    rd(12'h100, d); check("R5", d & 32'h20, 32'h0);
    rd(12'h104, d); check("R1", d & 32'h3F, 32'h06);

    // enables
    wr(12'h008, 32'h30); wr(12'h008, 32'h0);
    rd(12'h004, d); check("R8", d, 32'h31);
    wr(12'h004, 32'h10); wr(12'h004, 32'h0);
    rd(12'h004, d); check("R9", d, 32'h21);
    rd(12'h00C, d); check("R13", d, 32'h0);
    rd(12'h200, d); check("R13", d, 32'h0);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      pins = pins ^ ($urandom & $urandom & $urandom & $urandom);
      we = 0; re = 0;
      case ($urandom % 8)
        0, 1: begin
          re = 1;
          case ($urandom % 7)
            0: addr = 12'h000; 1: addr = 12'h004; 2: addr = 12'h100;
            3: addr = 12'h104; 4: addr = 12'h00C;
            default: addr = AW'(12'h180 + 4 * ($urandom % N));
          endcase
        end
        2: begin we = 1; addr = 12'h100; wdata = $urandom; end
        3: begin we = 1; addr = 12'h008; wdata = $urandom & $urandom; end
        4: begin we = 1; addr = 12'h004; wdata = $urandom & $urandom & $urandom; end
        5: begin
          we = 1; addr = AW'(12'h180 + 4 * ($urandom % N));
          case ($urandom % 7)
            0: wdata = 32'h01; 1: wdata = 32'h02; 2: wdata = 32'h04;
            3: wdata = 32'h08; 4: wdata = 32'h0C; 5: wdata = 32'h00;
            default: wdata = $urandom;
          endcase
        end
        default: ;
      endcase
    end
    @(negedge clk); we = 0; re = 0;
    idle(2);
    done = 1;
    summary();
  end
endmodule